// File: doc/BRIEF.md
# Gated Clock Frequency Counter

This block measures how fast one of several candidate clocks runs. Software picks a source by index, writes a window length and raises a run bit. The block steers the chosen clock into a counting stage and waits for that clock to settle. It then opens a gate window, timed in ticks of a 1 MHz timebase derived from the reference clock, and counts rising edges of the chosen clock while the gate is open. At the end it hands the final count back to the reference domain through a request/acknowledge handshake. Dividing the count by the window length gives the frequency. That conversion is left to software.

The counter is 20 bits wide by default. The window register holds up to 1023 ticks. A clock near 850 MHz therefore stays below the counter limit even at the longest window. A 640-tick window resolves about 1.56 kHz per count. The counting logic runs on the selected clock. The reference side reads the result only after the counting side has stopped and reported that it is finished, so the value it reads is never torn. Glitch-free switching between clocks is not part of this block. The source index is held constant for the whole measurement so that no switch happens while counting.

Top module: `clk_freq_meter`

## Requirements
- R1: After reset, `count` is 0, and `ovf`, `busy` and `done` are all 0.
- R2: A rising edge of `run` while idle starts a measurement. One reference cycle later `busy` is 1 and `done` is 0. `count` and `ovf` read 0 for as long as `busy` is 1. Holding `run` high after the measurement ends does not start another one.
- R3: `count` equals the number of rising edges of the selected source within a window of max(`win_len`,1) × TB_DIV reference cycles, accurate to within ±2 counts. A `win_len` of 0 acts as 1.
- R4: `src_sel` = k measures `src_clk[k]`. Bit k of `src_clk` is source k.
- R5: `src_sel` and `win_len` are sampled only when a measurement starts. Changing them while `busy` is 1 does not alter the result.
- R6: After a start, at least 24 cycles of the selected clock pass before the gate opens. So the time from the `run` edge to `done` is at least 24 source periods plus the window.
- R7: If more than 2^CNT_W−1 edges arrive in one window, `count` holds at 2^CNT_W−1 and `ovf` is 1. Otherwise `ovf` is 0.
- R8: `done` rises in the same cycle that `busy` falls, and the two are never 1 together. `done`, `count` and `ovf` then hold their values until the next start.
- R9: With the default CNT_W of 20, counts above 2^16 are returned in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| src_clk | input | N_SRC | Candidate clocks to measure |
| src_sel | input | SEL_W | Index of the source to measure |
| win_len | input | WIN_W | Gate window length in timebase ticks |
| run | input | 1 | Start a measurement on its rising edge |
| count | output | CNT_W | Final edge count |
| ovf | output | 1 | Count saturated during the last window |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | Result valid |

## Verification
The bench measures sources with unrelated periods over several window lengths, including a zero length. A design that selects the wrong clock, or times the window wrongly, returns a count that is off by much more than the ±2 tolerance. It moves the source index partway through a measurement. A design that does not latch the index would count the new clock. It times the run-to-done interval on a slow 25 MHz source. A design that skips the 24-cycle settling period finishes several hundred nanoseconds early. On a narrow 8-bit copy it overdrives the counter to check saturation and the overflow flag, and on the default copy it pushes the count past 16 bits. Together these catch a counter that wraps instead of holding, or one that drops its upper bits.

// File: rtl/clk_freq_meter_pkg.sv
package clk_freq_meter_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_GATE,
    ST_XFER,
    ST_DROP
  } meter_st_e;
endpackage

// File: rtl/cfm_sync.sv
module cfm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] r;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) r <= '0;
        else     r <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) r <= '0;
        else     r <= {r[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = r[STAGES-1];
endmodule

// File: rtl/cfm_src_mux.sv
module cfm_src_mux #(
  parameter int N_SRC = 4,
  parameter int SEL_W = 2
) (
  input  logic [N_SRC-1:0] src_clk,
  input  logic [SEL_W-1:0] sel,
  output logic             mclk
);
  assign mclk = src_clk[sel];
endmodule

// File: rtl/cfm_meas.sv
module cfm_meas #(
  parameter int CNT_W  = 20,
  parameter int SETTLE = 24,
  parameter int STAGES = 2
) (
  input  logic             mclk,
  input  logic             rst_m,
  input  logic             arm,
  input  logic             gate,
  output logic             settled,
  output logic             req,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  localparam int SET_W = $clog2(SETTLE + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic arm_s, gate_s, arm_d, gate_d;
  logic [SET_W-1:0] settle_q;

  cfm_sync #(.STAGES(STAGES)) u_arm_sync  (.clk(mclk), .rst(rst_m), .d(arm),  .q(arm_s));
  cfm_sync #(.STAGES(STAGES)) u_gate_sync (.clk(mclk), .rst(rst_m), .d(gate), .q(gate_s));

  always_ff @(posedge mclk) begin
    if (rst_m) begin
      arm_d    <= 1'b0;
      gate_d   <= 1'b0;
      settle_q <= '0;
      cnt      <= '0;
      ovf      <= 1'b0;
      req      <= 1'b0;
    end else begin
      arm_d  <= arm_s;
      gate_d <= gate_s;
      if (arm_s && !arm_d) begin
        settle_q <= '0;
        cnt      <= '0;
        ovf      <= 1'b0;
        req      <= 1'b0;
      end else if (!arm_s) begin
        settle_q <= '0;
        req      <= 1'b0;
      end else begin
        if (settle_q != SET_W'(SETTLE)) settle_q <= settle_q + 1'b1;
        if (gate_s && settle_q == SET_W'(SETTLE)) begin
          if (cnt == CNT_MAX) ovf <= 1'b1;
          else                cnt <= cnt + 1'b1;
        end
        if (gate_d && !gate_s) req <= 1'b1;
      end
    end
  end

  assign settled = (settle_q == SET_W'(SETTLE));

  assert_gate_after_settle_R6: assert property (@(posedge mclk) disable iff (rst_m)
    gate_s |-> settle_q == SET_W'(SETTLE));
  assert_saturate_R7: assert property (@(posedge mclk) disable iff (rst_m)
    ovf |-> cnt == CNT_MAX);
  assert_ovf_from_max_R7: assert property (@(posedge mclk) disable iff (rst_m)
    $rose(ovf) |-> $past(cnt) == CNT_MAX);
endmodule

// File: rtl/cfm_ctrl.sv
module cfm_ctrl
  import clk_freq_meter_pkg::*;
#(
  parameter int SEL_W  = 2,
  parameter int WIN_W  = 10,
  parameter int CNT_W  = 20,
  parameter int TB_DIV = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] src_sel,
  input  logic [WIN_W-1:0] win_len,
  input  logic             settled_s,
  input  logic             req_s,
  input  logic [CNT_W-1:0] cnt_m,
  input  logic             ovf_m,
  output logic [SEL_W-1:0] sel_q,
  output logic             arm,
  output logic             gate,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int DIV_W = (TB_DIV > 1) ? $clog2(TB_DIV) : 1;

  meter_st_e        state;
  logic             run_q;
  logic [WIN_W-1:0] win_q;
  logic [WIN_W-1:0] wcnt;
  logic [DIV_W-1:0] div;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      run_q   <= 1'b0;
      sel_q   <= '0;
      win_q   <= '0;
      wcnt    <= '0;
      div     <= '0;
      arm     <= 1'b0;
      gate    <= 1'b0;
      count_o <= '0;
      ovf_o   <= 1'b0;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      run_q <= run;
      case (state)
        ST_IDLE: if (run && !run_q) begin
          sel_q   <= src_sel;
          win_q   <= (win_len == '0) ? WIN_W'(1) : win_len;
          arm     <= 1'b1;
          busy_o  <= 1'b1;
          done_o  <= 1'b0;
          count_o <= '0;
          ovf_o   <= 1'b0;
          state   <= ST_SETTLE;
        end
        ST_SETTLE: if (settled_s) begin
          gate  <= 1'b1;
          div   <= '0;
          wcnt  <= '0;
          state <= ST_GATE;
        end
        ST_GATE: begin
          if (div == DIV_W'(TB_DIV - 1)) begin
            div <= '0;
            if (wcnt == win_q - 1'b1) begin
              gate  <= 1'b0;
              state <= ST_XFER;
            end else begin
              wcnt <= wcnt + 1'b1;
            end
          end else begin
            div <= div + 1'b1;
          end
        end
        ST_XFER: if (req_s) begin
          arm   <= 1'b0;
          state <= ST_DROP;
        end
        ST_DROP: if (!req_s && !settled_s) begin
          count_o <= cnt_m;
          ovf_o   <= ovf_m;
          busy_o  <= 1'b0;
          done_o  <= 1'b1;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_busy_done_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && done_o));
  assert_done_on_busy_fall_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $fell(busy_o));
  assert_count_clear_R2: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (count_o == '0 && !ovf_o));
  assert_sel_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> ($stable(sel_q) && $stable(win_q)));
  assert_window_bound_R3: assert property (@(posedge clk) disable iff (rst)
    gate |-> (wcnt < win_q));
endmodule

// File: rtl/clk_freq_meter.sv
module clk_freq_meter #(
  parameter int N_SRC  = 4,
  parameter int CNT_W  = 20,
  parameter int WIN_W  = 10,
  parameter int TB_DIV = 100,
  parameter int SETTLE = 24,
  parameter int STAGES = 2,
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_clk,
  input  logic [SEL_W-1:0] src_sel,
  input  logic [WIN_W-1:0] win_len,
  input  logic             run,
  output logic [CNT_W-1:0] count,
  output logic             ovf,
  output logic             busy,
  output logic             done
);
  logic [SEL_W-1:0] sel_q;
  logic             mclk, rst_m;
  logic             arm, gate;
  logic             settled_m, req_m, ovf_m;
  logic [CNT_W-1:0] cnt_m;
  logic             settled_s, req_s;

  cfm_src_mux #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_mux (
    .src_clk(src_clk), .sel(sel_q), .mclk(mclk));

  cfm_sync #(.STAGES(STAGES)) u_rst_sync (
    .clk(mclk), .rst(1'b0), .d(rst), .q(rst_m));

  cfm_meas #(.CNT_W(CNT_W), .SETTLE(SETTLE), .STAGES(STAGES)) u_meas (
    .mclk(mclk), .rst_m(rst_m), .arm(arm), .gate(gate),
    .settled(settled_m), .req(req_m), .cnt(cnt_m), .ovf(ovf_m));

  cfm_sync #(.STAGES(STAGES)) u_settled_sync (
    .clk(clk), .rst(rst), .d(settled_m), .q(settled_s));
  cfm_sync #(.STAGES(STAGES)) u_req_sync (
    .clk(clk), .rst(rst), .d(req_m), .q(req_s));

  cfm_ctrl #(.SEL_W(SEL_W), .WIN_W(WIN_W), .CNT_W(CNT_W), .TB_DIV(TB_DIV)) u_ctrl (
    .clk(clk), .rst(rst), .run(run), .src_sel(src_sel), .win_len(win_len),
    .settled_s(settled_s), .req_s(req_s), .cnt_m(cnt_m), .ovf_m(ovf_m),
    .sel_q(sel_q), .arm(arm), .gate(gate), .count_o(count), .ovf_o(ovf),
    .busy_o(busy), .done_o(done));
endmodule

// File: tb/clk_freq_meter_tb.sv
`timescale 1ns/1ps
module clk_freq_meter_tb;
  localparam int TBD = 200;
  localparam int REF_PS = 5000;
  localparam int PER_PS [0:3] = '{10000, 7000, 40000, 3000};
  localparam int NV = 6;
  localparam int V_SEL [0:NV-1] = '{0, 1, 2, 0, 3, 1};
  localparam int V_WIN [0:NV-1] = '{4, 4, 4, 2, 3, 0};

  logic clk = 1'b0, rst = 1'b1;
  logic c0 = 0, c1 = 0, c2 = 0, c3 = 0;
  logic [3:0] src_clk;
  logic [1:0] src_sel = '0;
  logic [9:0] win_len = '0;
  logic run = 1'b0, run_s = 1'b0;
  logic [19:0] count;
  logic [7:0]  count_s;
  logic ovf, busy, done, ovf_s, busy_s, done_s;
  int applied = 0, miscompares = 0;
  int cyc = 0;

  assign src_clk = {c3, c2, c1, c0};

  always #2.5 clk = ~clk;
  initial forever #5   c0 = ~c0;
  initial forever #3.5 c1 = ~c1;
  initial forever #20  c2 = ~c2;
  initial forever #1.5 c3 = ~c3;
  always @(posedge clk) cyc <= cyc + 1;

  clk_freq_meter #(.TB_DIV(TBD)) u_dut (
    .clk(clk), .rst(rst), .src_clk(src_clk), .src_sel(src_sel), .win_len(win_len),
    .run(run), .count(count), .ovf(ovf), .busy(busy), .done(done));

  clk_freq_meter #(.TB_DIV(TBD), .CNT_W(8)) u_sat (
    .clk(clk), .rst(rst), .src_clk(src_clk), .src_sel(src_sel), .win_len(win_len),
    .run(run_s), .count(count_s), .ovf(ovf_s), .busy(busy_s), .done(done_s));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    applied++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expect_cnt(input int sel, input int win);
    int w = (win == 0) ? 1 : win;
    return (w * TBD * REF_PS) / PER_PS[sel];
  endfunction

  function automatic bit near(input int a, input int e);
    return (a >= e - 2) && (a <= e + 2);
  endfunction

  // Start one measurement on the chosen instance, wait for done; returns elapsed ns
  task automatic measure(input bit sat, input int sel, input int win,
                         input bit swap_mid, output real elapsed);
    real t0;
    int n;
    @(negedge clk);
    src_sel = sel[1:0];
    win_len = win[9:0];
    if (sat) run_s = 1'b1; else run = 1'b1;
    t0 = $realtime;
    @(negedge clk);
    run = 1'b0; run_s = 1'b0;
    chk(sat ? (busy_s && !done_s && count_s == 0 && !ovf_s)
            : (busy && !done && count == 0 && !ovf), "R2 start", sat ? busy_s : busy, 1);
    if (swap_mid) begin
      src_sel = 2'd2;
      win_len = 10'd1;
    end
    n = 0;
    while (!(sat ? done_s : done) && n < 60000) begin
      @(negedge clk);
      n++;
      if (!sat) chk(busy || done, "R8 busy/done", busy, 1);
    end
    elapsed = $realtime - t0;
    chk(n < 60000, "watchdog", n, 0);
    chk(sat ? !busy_s : !busy, "R8 busy low at done", sat ? busy_s : busy, 0);
  endtask

  initial begin
    #(190000.0 * 5.0);
    miscompares++;
    applied++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    real el;
    int e;
    int hold_cnt;
    repeat (40) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(count == 0 && !ovf && !busy && !done, "R1 reset", {count, busy, done}, 0);
    chk(count_s == 0 && !ovf_s && !busy_s && !done_s, "R1 reset sat", count_s, 0);

    // Vector table: source, window, expected count (R3, R4)
    for (int i = 0; i < NV; i++) begin
      measure(1'b0, V_SEL[i], V_WIN[i], 1'b0, el);
      e = expect_cnt(V_SEL[i], V_WIN[i]);
      chk(near(int'(count), e), $sformatf("R3/R4 vec%0d sel=%0d win=%0d", i, V_SEL[i], V_WIN[i]),
          int'(count), e);
      chk(!ovf, "R7 no ovf", ovf, 0);
    end

    // R5: selection and window changed while busy are ignored
    measure(1'b0, 0, 4, 1'b1, el);
    chk(near(int'(count), 400), "R5 mid-run change", int'(count), 400);

    // R6: settle time on slow 40 ns source
    measure(1'b0, 2, 4, 1'b0, el);
    chk(el >= 4960.0, "R6 settle latency ns", int'(el), 4960);
    chk(near(int'(count), 100), "R6 count", int'(count), 100);

    // R2/R8: run held high does not restart, result holds
    @(negedge clk);
    src_sel = 2'd0; win_len = 10'd1; run = 1'b1;
    @(negedge clk);
    chk(busy, "R2 start held", busy, 1);
    while (!done) @(negedge clk);
    hold_cnt = int'(count);
    repeat (300) @(negedge clk);
    chk(!busy && done, "R2 held run no restart", busy, 0);
    chk(int'(count) == hold_cnt, "R8 count holds", int'(count), hold_cnt);
    run = 1'b0;
    chk(near(hold_cnt, 100), "R3 held window", hold_cnt, 100);

    // R9: count beyond 16 bits
    measure(1'b0, 3, 200, 1'b0, el);
    e = expect_cnt(3, 200);
    chk(near(int'(count), e), "R9 wide count", int'(count), e);

    // R7: saturation on narrow instance
    measure(1'b1, 3, 1, 1'b0, el);
    chk(count_s == 8'hFF, "R7 saturate", count_s, 255);
    chk(ovf_s, "R7 ovf flag", ovf_s, 1);
    measure(1'b1, 2, 1, 1'b0, el);
    chk(near(int'(count_s), 25), "R7 in range", count_s, 25);
    chk(!ovf_s, "R7 ovf cleared", ovf_s, 0);

    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule